// File: doc/BRIEF.md
# Shared-Memory Mailbox Load Sequencer

This block sits on the fabric side of a two-port on-chip RAM that a host processor fills. The RAM holds 402 words of 32 bits. The host writes a status word, and the sequencer polls it. A status code of 2 makes it reload all 400 filter coefficients for the left and right channels and then the next audio sample. A code of 1 makes it reload only the sample and skip the long coefficient fetch. A code of 0 means nothing is pending.

Once the sample register holds the new value, the sequencer starts the convolution engine with a one-cycle pulse and waits for it to finish. It then starts the audio FIFO writer the same way and waits for that to finish. Last, it clears the status word, which tells the host that the fabric is ready for the next update.

The block reads through a single synchronous RAM port. Each read takes three cycles. The coefficients and the sample come out as signed fixed-point values with 10 integer bits and 17 fraction bits, 27 bits in all. They feed the convolver directly.

Top module: `mb_load_seq`

## Requirements
- R1: A synchronous reset returns the sequencer to polling and clears all 400 tap registers and the sample register to zero. During and just after reset, no write, convolver start or FIFO start is asserted.
- R2: While the status word (address 401) reads 0, the RAM address stays at 401 and the word is read again and again. No other address is presented, no write is made and no start is issued.
- R3: Every RAM read holds its address for exactly three cycles: present, wait, capture. Data is taken in the third cycle, so a full coefficient fetch runs 1200 cycles from the first appearance of address 0 to the first appearance of address 400.
- R4: Status 2 reads addresses 0 to 399 in ascending order and then address 400. Word n loads left tap n when n < 200 and right tap n−200 otherwise.
- R5: Status 1 reads only address 400. No coefficient address is presented and every tap keeps its previous value.
- R6: A tap or sample value is bits 26:0 of its RAM word, a two's-complement 10.17 number. Bits 31:27 have no effect.
- R7: The status word is compared as a full 32-bit value. Any value other than 0, 1 or 2, for example 3 or 0x10000001, is treated as idle: no fetch, no start and no write.
- R8: After the sample is captured, conv_start pulses for one cycle. The block waits for conv_done, then pulses fifo_start for one cycle and waits for fifo_done.
- R9: The cycle after fifo_done is seen, the block makes a single write of 0 to address 401 and then resumes polling. No write happens at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 9 | Shared RAM word address |
| mem_rdata | input | 32 | Shared RAM read data, one-cycle registered latency or less |
| mem_wdata | output | 32 | Shared RAM write data |
| mem_we | output | 1 | Shared RAM write enable |
| conv_start | output | 1 | One-cycle start pulse to the convolution engine |
| conv_done | input | 1 | Convolution engine finished |
| fifo_start | output | 1 | One-cycle start pulse to the audio FIFO writer |
| fifo_done | input | 1 | Audio FIFO writer finished |
| tap_left | output | 200x27 | Left-channel coefficient registers, signed 10.17 |
| tap_right | output | 200x27 | Right-channel coefficient registers, signed 10.17 |
| sample_out | output | 27 | Current audio sample, signed 10.17 |

## Verification
The mailbox is driven with two full reloads and two sample-only updates.

The first full reload uses ascending coefficients with junk in the upper five bits, which shows whether those bits are masked and whether the left and right halves are split at the right word. The second uses descending negative values, which shows sign handling and whether every tap is overwritten.

The sample-only updates come after a full load. They check that no coefficient address appears and that the taps stay unchanged; one of them uses the most negative sample.

Idle polling, the out-of-range status codes 3 and 0x10000001, and a reset after a load show whether the code compare is exact and whether reset really clears the bank.

// File: rtl/mb_seq_pkg.sv
package mb_seq_pkg;

    // Status word codes shared with the host
    localparam int unsigned CODE_IDLE   = 0;
    localparam int unsigned CODE_SAMPLE = 1;
    localparam int unsigned CODE_FULL   = 2;

    typedef enum logic [2:0] {
        SEQ_POLL,
        SEQ_COEF,
        SEQ_SAMP,
        SEQ_CONV_GO,
        SEQ_CONV_WAIT,
        SEQ_FIFO_GO,
        SEQ_FIFO_WAIT,
        SEQ_ACK
    } seq_state_e;

endpackage

// File: rtl/mb_read_pace.sv
// Three-phase read pacer: present, wait, capture.
module mb_read_pace (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic capture
);
    localparam logic [1:0] LAST_PH = 2'd2;

    logic [1:0] ph_d, ph_q;

    always_comb begin
        ph_d = 2'd0;
        if (go) begin
            ph_d = (ph_q == LAST_PH) ? 2'd0 : ph_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 2'd0;
        else     ph_q <= ph_d;
    end

    assign capture = go && (ph_q == LAST_PH);
endmodule

// File: rtl/mb_tap_bank.sv
// Coefficient register file: left taps in the low half, right taps in the high half.
module mb_tap_bank #(
    parameter int TAPS  = 200,
    parameter int FX_W  = 27,
    parameter int IDX_W = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [FX_W-1:0]            wr_val,
    output logic [TAPS-1:0][FX_W-1:0]  left,
    output logic [TAPS-1:0][FX_W-1:0]  right
);
    localparam int ENTRIES = 2 * TAPS;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(ENTRIES);

    logic [ENTRIES-1:0][FX_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (wr_idx < LIMIT)) begin
            bank_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_split
        assign left[g]  = bank_q[g];
        assign right[g] = bank_q[TAPS + g];
    end
endmodule

// File: rtl/mb_ctrl.sv
// Mailbox sequencing FSM: poll, fetch, launch convolver, launch FIFO writer, acknowledge.
module mb_ctrl
    import mb_seq_pkg::*;
#(
    parameter int TAPS   = 200,
    parameter int FX_W   = 27,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata,
    input  logic              conv_done,
    input  logic              fifo_done,
    output logic              go,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              conv_start,
    output logic              fifo_start,
    output logic              tap_we,
    output logic [ADDR_W-1:0] tap_idx,
    output logic [FX_W-1:0]   tap_val,
    output logic [FX_W-1:0]   sample
);
    localparam logic [ADDR_W-1:0] SAMP_A    = ADDR_W'(2 * TAPS);
    localparam logic [ADDR_W-1:0] STAT_A    = ADDR_W'(2 * TAPS + 1);
    localparam logic [ADDR_W-1:0] LAST_COEF = ADDR_W'(2 * TAPS - 1);
    localparam logic [DATA_W-1:0] V_SAMPLE  = DATA_W'(CODE_SAMPLE);
    localparam logic [DATA_W-1:0] V_FULL    = DATA_W'(CODE_FULL);
    localparam logic [DATA_W-1:0] V_IDLE    = DATA_W'(CODE_IDLE);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] idx;
        logic [FX_W-1:0]   smp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        tap_we = 1'b0;
        case (r_q.st)
            SEQ_POLL: begin
                if (capture) begin
                    if (rdata == V_FULL) begin
                        r_d.st  = SEQ_COEF;
                        r_d.idx = '0;
                    end else if (rdata == V_SAMPLE) begin
                        r_d.st = SEQ_SAMP;
                    end
                end
            end
            SEQ_COEF: begin
                if (capture) begin
                    tap_we = 1'b1;
                    if (r_q.idx == LAST_COEF) r_d.st  = SEQ_SAMP;
                    else                      r_d.idx = r_q.idx + 1'b1;
                end
            end
            SEQ_SAMP: begin
                if (capture) begin
                    r_d.smp = rdata[FX_W-1:0];
                    r_d.st  = SEQ_CONV_GO;
                end
            end
            SEQ_CONV_GO:   r_d.st = SEQ_CONV_WAIT;
            SEQ_CONV_WAIT: if (conv_done) r_d.st = SEQ_FIFO_GO;
            SEQ_FIFO_GO:   r_d.st = SEQ_FIFO_WAIT;
            SEQ_FIFO_WAIT: if (fifo_done) r_d.st = SEQ_ACK;
            SEQ_ACK:       r_d.st = SEQ_POLL;
            default:       r_d.st = SEQ_POLL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= SEQ_POLL;
            r_q.idx <= '0;
            r_q.smp <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            SEQ_COEF: mem_addr = r_q.idx;
            SEQ_SAMP: mem_addr = SAMP_A;
            default:  mem_addr = STAT_A;
        endcase
    end

    assign go         = (r_q.st == SEQ_POLL) || (r_q.st == SEQ_COEF) || (r_q.st == SEQ_SAMP);
    assign mem_we     = (r_q.st == SEQ_ACK);
    assign mem_wdata  = V_IDLE;
    assign conv_start = (r_q.st == SEQ_CONV_GO);
    assign fifo_start = (r_q.st == SEQ_FIFO_GO);
    assign tap_idx    = r_q.idx;
    assign tap_val    = rdata[FX_W-1:0];
    assign sample     = r_q.smp;
endmodule

// File: rtl/mb_load_seq.sv
module mb_load_seq #(
    parameter int TAPS   = 200,
    parameter int FX_W   = 27,
    parameter int DATA_W = 32
) (
    input  logic                                          clk,
    input  logic                                          rst,
    output logic [$clog2(2*TAPS+2)-1:0]                   mem_addr,
    input  logic [DATA_W-1:0]                             mem_rdata,
    output logic [DATA_W-1:0]                             mem_wdata,
    output logic                                          mem_we,
    output logic                                          conv_start,
    input  logic                                          conv_done,
    output logic                                          fifo_start,
    input  logic                                          fifo_done,
    output logic [TAPS-1:0][FX_W-1:0]                     tap_left,
    output logic [TAPS-1:0][FX_W-1:0]                     tap_right,
    output logic [FX_W-1:0]                               sample_out
);
    localparam int WORDS  = 2 * TAPS + 2;
    localparam int ADDR_W = $clog2(WORDS);

    logic              go;
    logic              capture;
    logic              tap_we;
    logic [ADDR_W-1:0] tap_idx;
    logic [FX_W-1:0]   tap_val;

    mb_read_pace u_pace (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .capture (capture)
    );

    mb_ctrl #(
        .TAPS   (TAPS),
        .FX_W   (FX_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .rdata      (mem_rdata),
        .conv_done  (conv_done),
        .fifo_done  (fifo_done),
        .go         (go),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .conv_start (conv_start),
        .fifo_start (fifo_start),
        .tap_we     (tap_we),
        .tap_idx    (tap_idx),
        .tap_val    (tap_val),
        .sample     (sample_out)
    );

    mb_tap_bank #(
        .TAPS  (TAPS),
        .FX_W  (FX_W),
        .IDX_W (ADDR_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tap_we),
        .wr_idx (tap_idx),
        .wr_val (tap_val),
        .left   (tap_left),
        .right  (tap_right)
    );
endmodule

// File: rtl/mb_load_seq_chk.sv
module mb_load_seq_chk #(
    parameter int TAPS   = 200,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              conv_start,
    input logic              conv_done,
    input logic              fifo_start,
    input logic              fifo_done
);
    localparam logic [ADDR_W-1:0] SAMP_A = ADDR_W'(2 * TAPS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(2 * TAPS + 1);

    logic conv_open, conv_fin, fifo_open, fifo_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_open <= 1'b0;
            conv_fin  <= 1'b0;
            fifo_open <= 1'b0;
            fifo_fin  <= 1'b0;
        end else begin
            if (conv_start)                  conv_open <= 1'b1;
            else if (conv_open && conv_done) begin
                conv_open <= 1'b0;
                conv_fin  <= 1'b1;
            end
            if (fifo_start) begin
                conv_fin  <= 1'b0;
                fifo_open <= 1'b1;
            end else if (fifo_open && fifo_done) begin
                fifo_open <= 1'b0;
                fifo_fin  <= 1'b1;
            end
            if (mem_we) fifo_fin <= 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_we && !conv_start && !fifo_start));

    // R3
    coef_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr < SAMP_A && mem_addr != $past(mem_addr)) |=> $stable(mem_addr));

    // R3
    coef_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr < SAMP_A && mem_addr != $past(mem_addr)) |=> ##1 $stable(mem_addr));

    // R8
    conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R8
    fifo_order_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_start |-> conv_fin);

    // R9
    ack_target_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == STAT_A && mem_wdata == '0));

    // R9
    ack_after_fifo_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> fifo_fin);
endmodule

bind mb_load_seq mb_load_seq_chk #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .fifo_start (fifo_start),
    .fifo_done  (fifo_done)
);

// File: tb/tb_mb_load_seq.sv
module tb_mb_load_seq;
    localparam int CLK_NS   = 10;
    localparam int TAPS     = 200;
    localparam int FX_W     = 27;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 9;
    localparam int SAMP_A   = 2 * TAPS;
    localparam int STAT_A   = 2 * TAPS + 1;
    localparam int CONV_LAT = 5;
    localparam int FIFO_LAT = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [DATA_W-1:0] mem_wdata;
    logic mem_we, conv_start, fifo_start;
    logic conv_done = 1'b0;
    logic fifo_done = 1'b0;
    logic [TAPS-1:0][FX_W-1:0] tap_left, tap_right;
    logic [FX_W-1:0] sample_out;

    always #(CLK_NS / 2) clk = ~clk;

    mb_load_seq #(.TAPS(TAPS), .FX_W(FX_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .conv_start(conv_start),
        .conv_done(conv_done), .fifo_start(fifo_start), .fifo_done(fifo_done),
        .tap_left(tap_left), .tap_right(tap_right), .sample_out(sample_out)
    );

    // Shared RAM model: registered read, host port and fabric port
    logic [DATA_W-1:0] ram [0:STAT_A];
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_data = '0;

    initial for (int i = 0; i <= STAT_A; i++) ram[i] = '0;

    always @(posedge clk) begin
        if (mem_we)  ram[mem_addr]  <= mem_wdata;
        if (host_we) ram[host_addr] <= host_data;
        mem_rdata <= ram[mem_addr];
    end

    int n_checks = 0;
    int n_fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct {
        int              kind;
        logic [FX_W-1:0] smp;
    } item_t;

    item_t           exp_q[$];
    logic [FX_W-1:0] exp_bank [0:2*TAPS-1];

    initial for (int i = 0; i < 2 * TAPS; i++) exp_bank[i] = '0;

    // Monitor and convolver/FIFO responders
    int cyc = 0;
    int n_conv = 0;
    int n_wr = 0;
    int n_off = 0;
    int n_coef = 0;
    int coef_at_ack = 0;
    int t0 = 0;
    int conv_cnt = 0;
    int fifo_cnt = 0;
    int last_fifo_done = -10;
    bit conv_fin = 0;
    logic [ADDR_W-1:0] prev_addr = ADDR_W'(STAT_A);

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (int'(mem_addr) != STAT_A) n_off++;
                if (int'(mem_addr) < SAMP_A)  n_coef++;
                if (mem_addr == 0 && int'(prev_addr) == STAT_A) t0 = cyc;
                if (int'(mem_addr) == SAMP_A && int'(prev_addr) == SAMP_A - 1)
                    chk(cyc - t0 == 3 * 2 * TAPS, "R3 coefficient fetch length", 64'(cyc - t0), 64'(3 * 2 * TAPS));
                if (conv_start) begin
                    n_conv++;
                    if (exp_q.size() == 0) begin
                        chk(0, "R8 unexpected conv_start", 64'(n_conv), 64'(0));
                    end else begin
                        item_t it;
                        int bad_l, bad_r;
                        it = exp_q.pop_front();
                        chk(sample_out == it.smp, "R6 sample value", 64'(sample_out), 64'(it.smp));
                        bad_l = 0;
                        bad_r = 0;
                        for (int k = 0; k < TAPS; k++) begin
                            if (tap_left[k]  !== exp_bank[k])        bad_l++;
                            if (tap_right[k] !== exp_bank[TAPS + k]) bad_r++;
                        end
                        chk(bad_l == 0, "R4 left taps mismatched", 64'(bad_l), 64'(0));
                        chk(bad_r == 0, "R4 right taps mismatched", 64'(bad_r), 64'(0));
                        if (it.kind == 1)
                            chk(n_coef == coef_at_ack, "R5 coefficient address read", 64'(n_coef - coef_at_ack), 64'(0));
                    end
                end
                if (fifo_start) begin
                    chk(conv_fin, "R8 fifo_start before conv_done", 64'(conv_fin), 64'(1));
                    conv_fin = 0;
                end
                if (mem_we) begin
                    n_wr++;
                    chk(int'(mem_addr) == STAT_A && mem_wdata == 0, "R9 ack target",
                        {23'd0, mem_addr, mem_wdata}, 64'(STAT_A) << 32);
                    chk(last_fifo_done == cyc - 1, "R9 ack timing", 64'(last_fifo_done), 64'(cyc - 1));
                    coef_at_ack = n_coef;
                end
            end
            prev_addr = mem_addr;
            // responders
            conv_done = 1'b0;
            fifo_done = 1'b0;
            if (!rst && conv_start) conv_cnt = CONV_LAT;
            else if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0) begin conv_done = 1'b1; conv_fin = 1; end
            end
            if (!rst && fifo_start) fifo_cnt = FIFO_LAT;
            else if (fifo_cnt > 0) begin
                fifo_cnt--;
                if (fifo_cnt == 0) begin fifo_done = 1'b1; last_fifo_done = cyc; end
            end
        end
    end

    task automatic host_write(input int addr, input logic [DATA_W-1:0] data);
        host_we   = 1'b1;
        host_addr = ADDR_W'(addr);
        host_data = data;
        @(negedge clk);
        host_we   = 1'b0;
    endtask

    // Driver: fill the mailbox, push the expected item, wait for the acknowledge
    task automatic host_post(input int kind, input int pat, input logic [FX_W-1:0] smp, input logic [4:0] junk);
        item_t it;
        if (kind == 2) begin
            for (int n = 0; n < 2 * TAPS; n++) begin
                logic [FX_W-1:0] v;
                if (pat == 0) v = FX_W'(n * 37 + 5);
                else          v = FX_W'(-((n + 1) * 1000));
                exp_bank[n] = v;
                host_write(n, {junk, v});
            end
        end
        host_write(SAMP_A, {junk, smp});
        it.kind = kind;
        it.smp  = smp;
        exp_q.push_back(it);
        host_write(STAT_A, DATA_W'(kind));
        while (ram[STAT_A] != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_probe(input logic [DATA_W-1:0] code, input string tag);
        int c0, w0, k0;
        host_write(STAT_A, code);
        c0 = n_conv; w0 = n_wr; k0 = n_coef;
        repeat (60) @(negedge clk);
        chk(n_conv == c0 && n_coef == k0, {tag, " fetch or start"}, 64'(n_conv - c0 + n_coef - k0), 64'(0));
        chk(n_wr == w0 && ram[STAT_A] == code, {tag, " status overwritten"}, 64'(ram[STAT_A]), 64'(code));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 64'(cyc), 64'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int off0, c0, w0, bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < TAPS; k++) if (tap_left[k] != 0 || tap_right[k] != 0) bad++;
        chk(bad == 0 && sample_out == 0, "R1 reset clears registers", 64'(bad), 64'(0));
        chk(!mem_we && !conv_start && !fifo_start, "R1 reset outputs quiet",
            {mem_we, conv_start, fifo_start}, 64'(0));
        // R2: idle polling
        off0 = n_off; c0 = n_conv; w0 = n_wr;
        repeat (60) @(negedge clk);
        chk(n_off == off0, "R2 address left status word", 64'(n_off - off0), 64'(0));
        chk(n_conv == c0 && n_wr == w0, "R2 activity while idle", 64'(n_conv - c0 + n_wr - w0), 64'(0));

        host_post(2, 0, 27'h0000123, 5'b10101);   // R4 R6 ascending with junk upper bits
        host_post(1, 0, 27'h7FFFFFF, 5'b01010);   // R5 sample only
        host_post(2, 1, 27'h0ABCDEF, 5'b00000);   // R4 negative descending taps
        host_post(1, 0, 27'h4000000, 5'b11111);   // R5 most negative sample
        chk(n_wr == 4, "R9 acknowledge count", 64'(n_wr), 64'(4));
        chk(exp_q.size() == 0, "R8 convolver starts missing", 64'(exp_q.size()), 64'(0));

        idle_probe(32'd3, "R7 code 3");
        idle_probe(32'h10000001, "R7 code 0x10000001");
        host_write(STAT_A, 32'd0);
        repeat (6) @(negedge clk);

        // R1: reset after a load clears the bank
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < TAPS; k++) if (tap_left[k] != 0 || tap_right[k] != 0) bad++;
        chk(bad == 0, "R1 reset after load clears taps", 64'(bad), 64'(0));
        chk(sample_out == 0, "R1 reset after load clears sample", 64'(sample_out), 64'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule